// File: doc/BRIEF.md
# Tightly Coupled Memory Access Router

This block sits on a processor load/store port and decides, for every request, whether the physical address falls inside one of up to four on-chip tightly coupled memory banks or must go out on the cache and external memory path. Each bank has a base address and an enable, both held in registers that a simple configuration port writes. All banks are the same power-of-two size, set by a parameter between 4 KB and 64 KB, and each base is aligned to that size. Decoding uses physical addresses only, so aliasing between virtual mappings needs no maintenance and the block has no clean or invalidate interface. One instance serves the data side and a second instance serves the instruction side.

Routing is combinational. A request that hits a bank drives a one-hot bank select, the byte offset inside the bank, and the unchanged write enable, byte enables and write data to the bank side in the same cycle. Such a request never reaches the external path, and so it is never looked up in the cache or allocated into it. Memory attributes that make no sense for local SRAM are rewritten. A read hit returns the selected bank's data one cycle later with a one-cycle valid pulse. Enabling two banks at the same base is an illegal setup. In that case the lowest-numbered bank wins and a sticky error flag is raised.

Top module: `tcm_router`

## Requirements
- R1: After reset all banks are disabled, `overlap_err` and `rd_valid` are 0, and every valid request goes to the external path.
- R2: A valid request whose address bits [ADDR_W-1:BANK_AW] equal the tag of an enabled bank raises `tcm_req`, drives bit i of `tcm_sel` for that bank i, and keeps `ext_req` low, all in the same cycle.
- R3: On a hit, `tcm_offset` equals the address minus the bank base, which is address bits [BANK_AW-1:0]. With the default BANK_AW of 14, a bank spans 0x0000 to 0x3FFF.
- R4: A write that hits a bank never raises `ext_req`, even when its attribute marks the region cacheable write-through.
- R5: The attribute is 5 bits: [4:3] memory type (0 normal, 1 device, 2 strongly ordered, 3 reserved), [2] shareable, [1] cacheable, [0] write-through. On a hit with a type other than 0, or with shareable set, `tcm_attr` is 5'b00000 (normal, non-shareable, non-cacheable).
- R6: On a hit with type 0 and shareable clear, `tcm_attr` equals `req_attr`. On a miss, `ext_attr`, `ext_addr`, `ext_we`, `ext_be` and `ext_wdata` equal the request fields.
- R7: On a hit, `tcm_we`, `tcm_be` and `tcm_wdata` equal `req_we`, `req_be` and `req_wdata`.
- R8: When several enabled banks match one address, only the lowest-numbered one is selected.
- R9: `overlap_err` rises one clock after two enabled banks hold the same tag. It then stays at 1, even after the setup is corrected, until reset.
- R10: A read hit gives `rd_valid` high for exactly the next cycle, with `rd_data` equal to that bank's slice of `bank_rdata`. Writes and misses give no pulse.
- R11: A disabled bank never hits, even when its tag matches the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Bank index being configured |
| cfg_en | input | 1 | Enable value for that bank |
| cfg_tag | input | TAG_W | Base address bits [ADDR_W-1:BANK_AW] for that bank |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| req_attr | input | 5 | Memory attributes (encoding in R5) |
| tcm_req | output | 1 | Request goes to a bank |
| tcm_sel | output | NUM_BANKS | One-hot bank select |
| tcm_offset | output | BANK_AW | Byte offset inside the bank |
| tcm_we | output | 1 | Bank write enable |
| tcm_be | output | DATA_W/8 | Bank byte enables |
| tcm_wdata | output | DATA_W | Bank write data |
| tcm_attr | output | 5 | Attributes after rewriting |
| bank_rdata | input | NUM_BANKS*DATA_W | Read data from each bank, bank i at slice i |
| rd_valid | output | 1 | Read data valid, one cycle after a read hit |
| rd_data | output | DATA_W | Read data from the bank that was hit |
| ext_req | output | 1 | Request goes to the cache and external path |
| ext_addr | output | ADDR_W | Forwarded address |
| ext_we | output | 1 | Forwarded write enable |
| ext_be | output | DATA_W/8 | Forwarded byte enables |
| ext_wdata | output | DATA_W | Forwarded write data |
| ext_attr | output | 5 | Forwarded attributes |
| overlap_err | output | 1 | Sticky flag for overlapping enabled banks |

## Verification
The hardest case to reach from the ports is an overlap. Two banks must be enabled at the same base, and a request must then land in the shared range while a higher-numbered bank also matches. Random traffic on its own never creates that setup. The stimulus therefore reprograms a high-numbered bank onto the tag of a lower one, sends a request into the shared window, and moves the bank away again, which shows both the priority and the stickiness of the flag. Random requests are aimed at the programmed tags, including the tag of a disabled bank, so hits, misses and every attribute type occur often.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    MT_NORMAL = 2'd0,
    MT_DEVICE = 2'd1,
    MT_STRONG = 2'd2,
    MT_RSVD   = 2'd3
  } mem_type_e;

  typedef struct packed {
    mem_type_e mtype;
    logic      shareable;
    logic      cacheable;
    logic      wthrough;
  } mem_attr_t;

  localparam int ATTR_W = $bits(mem_attr_t);

endpackage

// File: rtl/tcm_bank_regs.sv
module tcm_bank_regs #(
  parameter int NUM_BANKS = 4,
  parameter int TAG_W     = 18,
  parameter int IDX_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic                            cfg_en,
  input  logic [TAG_W-1:0]                cfg_tag,
  output logic [NUM_BANKS-1:0]            bank_en,
  output logic [NUM_BANKS-1:0][TAG_W-1:0] bank_tag,
  output logic                            overlap_err
);

  logic clash;

  // one register bank per TCM bank, written by index
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en  <= '0;
      bank_tag <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (cfg_idx == IDX_W'(i)) begin
          bank_en[i]  <= cfg_en;
          bank_tag[i] <= cfg_tag;
        end
      end
    end
  end

  // pairwise compare of enabled banks; equal tags mean equal ranges
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      for (int j = i + 1; j < NUM_BANKS; j++) begin
        if (bank_en[i] && bank_en[j] && (bank_tag[i] == bank_tag[j]))
          clash = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        overlap_err <= 1'b0;
    else if (clash) overlap_err <= 1'b1;
  end

  // R9: flag never drops without reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    overlap_err |=> overlap_err);

  // R1: banks come out of reset disabled
  a_r1_banks_off: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_en == '0));

endmodule

// File: rtl/tcm_hit_decode.sv
module tcm_hit_decode #(
  parameter int NUM_BANKS = 4,
  parameter int TAG_W     = 18,
  parameter int IDX_W     = 2
) (
  input  logic [TAG_W-1:0]                addr_tag,
  input  logic [NUM_BANKS-1:0]            bank_en,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0] bank_tag,
  output logic [NUM_BANKS-1:0]            sel,
  output logic [IDX_W-1:0]                idx,
  output logic                            hit
);

  // fixed priority: lowest-numbered matching bank wins
  always_comb begin
    sel = '0;
    idx = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (!hit && bank_en[i] && (bank_tag[i] == addr_tag)) begin
        sel[i] = 1'b1;
        idx    = IDX_W'(i);
        hit    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcm_attr_fix.sv
module tcm_attr_fix
  import tcm_pkg::*;
(
  input  mem_attr_t attr_in,
  output mem_attr_t attr_out
);

  // local SRAM is never shared or device-like; demote such accesses
  always_comb begin
    attr_out = attr_in;
    if ((attr_in.mtype != MT_NORMAL) || attr_in.shareable) begin
      attr_out.mtype     = MT_NORMAL;
      attr_out.shareable = 1'b0;
      attr_out.cacheable = 1'b0;
      attr_out.wthrough  = 1'b0;
    end
  end

endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int BANK_AW   = 14,   // bank size 2**BANK_AW bytes, 12..16
  localparam int TAG_W    = ADDR_W - BANK_AW,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic                          cfg_en,
  input  logic [TAG_W-1:0]              cfg_tag,
  input  logic                          req_valid,
  input  logic                          req_we,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BE_W-1:0]               req_be,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [4:0]                    req_attr,
  output logic                          tcm_req,
  output logic [NUM_BANKS-1:0]          tcm_sel,
  output logic [BANK_AW-1:0]            tcm_offset,
  output logic                          tcm_we,
  output logic [BE_W-1:0]               tcm_be,
  output logic [DATA_W-1:0]             tcm_wdata,
  output logic [4:0]                    tcm_attr,
  input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          ext_req,
  output logic [ADDR_W-1:0]             ext_addr,
  output logic                          ext_we,
  output logic [BE_W-1:0]               ext_be,
  output logic [DATA_W-1:0]             ext_wdata,
  output logic [4:0]                    ext_attr,
  output logic                          overlap_err
);

  logic [NUM_BANKS-1:0]            bank_en;
  logic [NUM_BANKS-1:0][TAG_W-1:0] bank_tag;
  logic [NUM_BANKS-1:0]            dec_sel;
  logic [IDX_W-1:0]                dec_idx;
  logic                            dec_hit;
  mem_attr_t                       attr_in;
  mem_attr_t                       attr_fixed;
  logic [IDX_W-1:0]                rd_idx_q;
  logic                            any_hit;

  tcm_bank_regs #(
    .NUM_BANKS (NUM_BANKS),
    .TAG_W     (TAG_W),
    .IDX_W     (IDX_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_en      (cfg_en),
    .cfg_tag     (cfg_tag),
    .bank_en     (bank_en),
    .bank_tag    (bank_tag),
    .overlap_err (overlap_err)
  );

  tcm_hit_decode #(
    .NUM_BANKS (NUM_BANKS),
    .TAG_W     (TAG_W),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr_tag (req_addr[ADDR_W-1:BANK_AW]),
    .bank_en  (bank_en),
    .bank_tag (bank_tag),
    .sel      (dec_sel),
    .idx      (dec_idx),
    .hit      (dec_hit)
  );

  assign attr_in = mem_attr_t'(req_attr);

  tcm_attr_fix u_attr (
    .attr_in  (attr_in),
    .attr_out (attr_fixed)
  );

  assign any_hit = req_valid && dec_hit;

  // bank side: base is size-aligned, so offset is the low address bits
  assign tcm_req    = any_hit;
  assign tcm_sel    = req_valid ? dec_sel : '0;
  assign tcm_offset = req_addr[BANK_AW-1:0];
  assign tcm_we     = req_we;
  assign tcm_be     = req_be;
  assign tcm_wdata  = req_wdata;
  assign tcm_attr   = attr_fixed;

  // external side: only misses, so hits never reach the cache
  assign ext_req    = req_valid && !dec_hit;
  assign ext_addr   = req_addr;
  assign ext_we     = req_we;
  assign ext_be     = req_be;
  assign ext_wdata  = req_wdata;
  assign ext_attr   = req_attr;

  // read return: banks answer one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      rd_valid <= any_hit && !req_we;
      if (any_hit && !req_we) rd_idx_q <= dec_idx;
    end
  end

  assign rd_data = bank_rdata[rd_idx_q*DATA_W +: DATA_W];

  // R1: no stale read pulse out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rd_valid);

  // R2: exactly one bank selected on a hit
  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (rst)
    tcm_req |-> $onehot(tcm_sel));

  // R4: hits never leak to the external path
  a_r4_no_ext_on_hit: assert property (@(posedge clk) disable iff (rst)
    tcm_req |-> !ext_req);

  // R5: demoted attributes on device/strong/shareable hits
  a_r5_attr_demote: assert property (@(posedge clk) disable iff (rst)
    (tcm_req && ((req_attr[4:3] != 2'd0) || req_attr[2])) |-> (tcm_attr == 5'd0));

  // R10: read hit produces a pulse next cycle
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    (tcm_req && !tcm_we) |=> rd_valid);

  // R10: no pulse without a preceding read hit
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(tcm_req && !tcm_we));

endmodule

// File: tb/tcm_router_test.sv
module tcm_router_test;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NB     = 4;
  localparam int BAW    = 14;
  localparam int TW     = ADDR_W - BAW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_idx = '0;
  logic              cfg_en = 1'b0;
  logic [TW-1:0]     cfg_tag = '0;
  logic              req_valid = 1'b0;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [4:0]        req_attr = '0;
  logic              tcm_req;
  logic [NB-1:0]     tcm_sel;
  logic [BAW-1:0]    tcm_offset;
  logic              tcm_we;
  logic [3:0]        tcm_be;
  logic [DATA_W-1:0] tcm_wdata;
  logic [4:0]        tcm_attr;
  logic [NB*DATA_W-1:0] bank_rdata;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              ext_req;
  logic [ADDR_W-1:0] ext_addr;
  logic              ext_we;
  logic [3:0]        ext_be;
  logic [DATA_W-1:0] ext_wdata;
  logic [4:0]        ext_attr;
  logic              overlap_err;

  int checks = 0;
  int fails  = 0;

  logic [TW-1:0] m_tag [NB];
  bit            m_en  [NB];

  always #10 clk = ~clk;

  // each bank returns a fixed pattern carrying its index
  always_comb
    for (int i = 0; i < NB; i++) bank_rdata[i*DATA_W +: DATA_W] = 32'hB0B0_0000 + i;

  tcm_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_tag(cfg_tag), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_attr(req_attr), .tcm_req(tcm_req),
    .tcm_sel(tcm_sel), .tcm_offset(tcm_offset), .tcm_we(tcm_we), .tcm_be(tcm_be),
    .tcm_wdata(tcm_wdata), .tcm_attr(tcm_attr), .bank_rdata(bank_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ext_req(ext_req), .ext_addr(ext_addr),
    .ext_we(ext_we), .ext_be(ext_be), .ext_wdata(ext_wdata), .ext_attr(ext_attr),
    .overlap_err(overlap_err)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_bank(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < NB; i++)
      if (m_en[i] && m_tag[i] == a[ADDR_W-1:BAW]) return i;
    return -1;
  endfunction

  function automatic logic [4:0] exp_attr(input logic [4:0] a);
    if (a[4:3] != 2'd0 || a[2]) return 5'd0;
    return a;
  endfunction

  task automatic cfg(input int idx, input bit en, input logic [TW-1:0] tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_en = en; cfg_tag = tag;
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[idx] = en; m_tag[idx] = tag;
  endtask

  task automatic do_req(input bit we, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                        input logic [DATA_W-1:0] wd, input logic [4:0] at,
                        input string sel_req);
    int b;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be;
    req_wdata = wd; req_attr = at;
    #1;
    b = exp_bank(a);
    if (b >= 0) begin
      check(tcm_req && !ext_req, "R2", "route to bank", {tcm_req, ext_req}, 2'b10);
      check(tcm_sel == NB'(1 << b), sel_req, "bank select", tcm_sel, 1 << b);
      check(tcm_offset == a[BAW-1:0], "R3", "offset", tcm_offset, a[BAW-1:0]);
      check(tcm_we == we && tcm_be == be && tcm_wdata == wd, "R7", "bank fields",
            {tcm_we, tcm_be, tcm_wdata}, {we, be, wd});
      if (at[4:3] != 2'd0 || at[2])
        check(tcm_attr == exp_attr(at), "R5", "demoted attr", tcm_attr, exp_attr(at));
      else
        check(tcm_attr == exp_attr(at), "R6", "kept attr", tcm_attr, exp_attr(at));
      if (we && at[1] && at[0])
        check(!ext_req, "R4", "write-through hit kept local", ext_req, 0);
    end else begin
      check(ext_req && !tcm_req, "R11", "route to external", {ext_req, tcm_req}, 2'b10);
      check(ext_addr == a && ext_we == we && ext_be == be && ext_wdata == wd &&
            ext_attr == at, "R6", "external fields",
            {ext_attr, ext_we, ext_be, ext_addr}, {at, we, be, a});
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(rd_valid == (b >= 0 && !we), "R10", "read valid", rd_valid, (b >= 0 && !we));
    if (b >= 0 && !we)
      check(rd_data == 32'hB0B0_0000 + b, "R10", "read data", rd_data, 32'hB0B0_0000 + b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected done");
    report();
  end

  initial begin
    logic [ADDR_W-1:0] a;
    int r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin m_en[i] = 0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(overlap_err == 0 && rd_valid == 0, "R1", "reset outputs", {overlap_err, rd_valid}, 0);
    // all banks disabled: a zero address must go external
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h0; req_attr = 5'd0;
    #1;
    check(ext_req && !tcm_req, "R1", "disabled after reset", {ext_req, tcm_req}, 2'b10);
    @(negedge clk); req_valid = 1'b0;

    cfg(0, 1, 18'h04000);
    cfg(1, 1, 18'h04001);
    cfg(2, 1, 18'h08000);
    cfg(3, 0, 18'h0C003);   // programmed but disabled

    // R11: tag of disabled bank 3
    do_req(1'b0, 32'h3000_C010, 4'hF, 32'h0, 5'b00_0_1_0, "R2");
    // R4: write-through cacheable write hit
    do_req(1'b1, 32'h1000_0004, 4'b0101, 32'hDEAD_BEEF, 5'b00_0_1_1, "R2");
    // R5: device and strongly ordered read hits, shareable normal hit
    do_req(1'b0, 32'h1000_4008, 4'hF, 32'h0, 5'b01_0_1_1, "R2");
    do_req(1'b0, 32'h2000_0000, 4'hF, 32'h0, 5'b10_1_0_0, "R2");
    do_req(1'b1, 32'h2000_0010, 4'h3, 32'h1234_5678, 5'b00_1_1_0, "R2");
    // R3: bank boundaries, then just past bank 1
    do_req(1'b0, 32'h1000_4000, 4'hF, 32'h0, 5'b00_0_1_1, "R2");
    do_req(1'b0, 32'h1000_7FFF, 4'h8, 32'h0, 5'b00_0_1_0, "R2");
    do_req(1'b0, 32'h1000_8000, 4'hF, 32'h0, 5'b00_0_1_0, "R2");
    // R10: pulse lasts one cycle
    @(negedge clk);
    check(rd_valid == 0, "R10", "pulse ends", rd_valid, 0);
    check(overlap_err == 0, "R9", "no overlap yet", overlap_err, 0);

    for (int n = 0; n < 400; n++) begin
      r = $urandom % 6;
      a = $urandom;
      if (r < NB) a[ADDR_W-1:BAW] = m_tag[r];
      do_req(1'($urandom), a, 4'($urandom), $urandom, 5'($urandom), "R2");
    end

    // R8/R9: bank 3 placed onto bank 1
    cfg(3, 1, 18'h04001);
    @(negedge clk);
    check(overlap_err == 1, "R9", "overlap flagged", overlap_err, 1);
    do_req(1'b0, 32'h1000_4010, 4'hF, 32'h0, 5'b00_0_0_0, "R8");
    do_req(1'b1, 32'h1000_7FF0, 4'hF, 32'hCAFE_0001, 5'b00_0_1_1, "R8");
    cfg(3, 1, 18'h0C003);
    @(negedge clk);
    check(overlap_err == 1, "R9", "flag sticky after fix", overlap_err, 1);
    do_req(1'b0, 32'h3000_C000, 4'hF, 32'h0, 5'b00_0_0_0, "R2");

    // R1: reset clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NB; i++) m_en[i] = 0;
    #1;
    check(overlap_err == 0, "R1", "flag cleared by reset", overlap_err, 0);
    do_req(1'b0, 32'h1000_0000, 4'hF, 32'h0, 5'b00_0_1_0, "R2");
    report();
  end

endmodule